// File: doc/BRIEF.md
# Program Counter with Return Stack

This block sequences instruction fetch for a small 8-bit controller with separate program and data stores. It keeps a 13-bit fetch address that covers an 8K-word program space. The address moves forward on an advance strobe, jumps on call, return and interrupt events, and accepts computed jumps through a byte-wide write to its low byte. A separate 8-bit latch register holds the upper address bits for computed jumps. Writing that latch does nothing to the fetch address until the low byte is written.

Return addresses live in an 8-entry circular hardware stack that software cannot address. The stack raises no overflow or underflow flag: a ninth push replaces the oldest entry, and an extra pop returns whatever slot the pointer wraps to. A global interrupt-enable flag is cleared when an interrupt is taken and set again by a return-from-interrupt. While the flag is clear, interrupt requests are ignored. When several strobes arrive in the same cycle, a fixed priority decides which one acts.

Top module: `pcs_top`

## Requirements
- R1: After reset the fetch address is 0x0000, the latch readback is 0x00, the interrupt-enable flag is 1 and every stack entry holds 0, so a return issued straight after reset loads 0x0000.
- R2: With only the advance strobe active, the fetch address rises by one on the next clock and wraps from 0x1FFF to 0x0000; with no strobe active it holds its value.
- R3: A call pushes the current address plus one and loads the 13-bit call target on the next clock.
- R4: A return pops the most recently pushed entry into the fetch address, so nested calls unwind in last-in, first-out order.
- R5: An interrupt request taken while the enable flag is 1 pushes the current address (not plus one), loads the vector address 0x0004 and clears the flag; while the flag is 0 a request is ignored and lower-priority strobes act instead.
- R6: A return-from-interrupt pops the stack into the fetch address and sets the enable flag to 1.
- R7: A latch write stores data bits 4:0. The latch readback shows those bits with bits 7:5 always 0, and the write leaves the fetch address unchanged.
- R8: A low-byte write loads the fetch address with {latch bits 4:0, written byte}, using the latch value held before that clock even if the latch is written in the same cycle. The low-byte readback always equals fetch address bits 7:0.
- R9: The stack pointer wraps modulo 8: after nine pushes the first return address is lost, and popping past the oldest remaining entry returns the stale contents of the wrapped slot.
- R10: Simultaneous strobes resolve in this order: interrupt entry (when enabled), then return or return-from-interrupt, then call, then low-byte write, then advance; the latch write acts independently of this order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Sequential advance strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| irq_i | input | 1 | Interrupt-entry request |
| reti_i | input | 1 | Return-from-interrupt strobe |
| tgt_i | input | 13 | Call target address |
| pcl_we_i | input | 1 | Low-byte write enable |
| pcl_wd_i | input | 8 | Low-byte write data |
| lat_we_i | input | 1 | Latch write enable |
| lat_wd_i | input | 8 | Latch write data |
| fetch_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Low-byte readback |
| lat_o | output | 8 | Latch readback |
| gie_o | output | 1 | Global interrupt-enable flag |

## Verification
The assertions check on every cycle the single-event transitions of the fetch address: a lone advance adds one, an idle cycle holds, a lone call lands on the target, a lone low-byte write forms {latch, byte}, and a taken interrupt lands on the vector with the flag cleared. They also check that the latch readback keeps its upper bits at zero, that a latch write alone leaves the address stable, and that a return-from-interrupt sets the flag. Return-stack contents are visible only through later pops. Last-in, first-out unwinding, loss of the oldest entry after nine pushes, stale wrapped pops and the full priority mix are therefore shown only by the bench's scenarios, which compare against a reference model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // Winning sequencing event for one cycle
   typedef enum logic [2:0] {
      EV_HOLD = 3'd0,
      EV_IRQ  = 3'd1,
      EV_POP  = 3'd2,
      EV_CALL = 3'd3,
      EV_PCL  = 3'd4,
      EV_ADV  = 3'd5
   } pcs_ev_e;

endpackage

// File: rtl/pcs_arb.sv
module pcs_arb
   import pcs_pkg::*;
(
   input  logic    irq_i,
   input  logic    gie_i,
   input  logic    ret_i,
   input  logic    reti_i,
   input  logic    call_i,
   input  logic    pcl_we_i,
   input  logic    adv_i,
   output pcs_ev_e ev_o
);

   // Fixed priority: interrupt, pop, call, low-byte write, advance
   always_comb begin
      if (irq_i && gie_i)        ev_o = EV_IRQ;
      else if (ret_i || reti_i)  ev_o = EV_POP;
      else if (call_i)           ev_o = EV_CALL;
      else if (pcl_we_i)         ev_o = EV_PCL;
      else if (adv_i)            ev_o = EV_ADV;
      else                       ev_o = EV_HOLD;
   end

endmodule

// File: rtl/pcs_hold.sv
module pcs_hold #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned HI_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [REG_W-1:0] wd_i,
   output logic [HI_W-1:0]  hi_o,
   output logic [REG_W-1:0] rd_o
);

   logic [HI_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    hold_q <= '0;
      else if (we_i) hold_q <= wd_i[HI_W-1:0];
   end

   assign hi_o = hold_q;

   // Unused upper bits carry no state and read as zero
   generate
      if (REG_W > HI_W) begin : g_pad
         assign rd_o = {{(REG_W-HI_W){1'b0}}, hold_q};
      end else begin : g_full
         assign rd_o = hold_q;
      end
   endgenerate

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
   parameter int unsigned W     = 13,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] top_o
);

   localparam int unsigned SP_W = $clog2(DEPTH);

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_dec;
   logic [W-1:0]    ents [DEPTH];

   assign sp_dec = sp_q - {{(SP_W-1){1'b0}}, 1'b1};

   // Pointer names the next free slot and wraps modulo DEPTH
   always_ff @(posedge clk) begin
      if (!rst_n)      sp_q <= '0;
      else if (push_i) sp_q <= sp_q + {{(SP_W-1){1'b0}}, 1'b1};
      else if (pop_i)  sp_q <= sp_dec;
   end

   generate
      for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
         logic [W-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             ent_q <= '0;
            else if (push_i && (sp_q == SP_W'(g))) ent_q <= din_i;
         end
         assign ents[g] = ent_q;
      end
   endgenerate

   assign top_o = ents[sp_dec];

endmodule

// File: rtl/pcs_top.sv
module pcs_top
   import pcs_pkg::*;
#(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned VEC_ADDR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             call_i,
   input  logic             ret_i,
   input  logic             irq_i,
   input  logic             reti_i,
   input  logic [PC_W-1:0]  tgt_i,
   input  logic             pcl_we_i,
   input  logic [REG_W-1:0] pcl_wd_i,
   input  logic             lat_we_i,
   input  logic [REG_W-1:0] lat_wd_i,
   output logic [PC_W-1:0]  fetch_o,
   output logic [REG_W-1:0] pcl_o,
   output logic [REG_W-1:0] lat_o,
   output logic             gie_o
);

   localparam int unsigned HI_W = PC_W - REG_W;
   localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);
   localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

   // Elaboration-time parameter checks
   generate
      if (PC_W <= REG_W || PC_W > 2*REG_W) begin : g_bad_width
         $error("pcs_top: PC_W must exceed REG_W and fit in two register bytes");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("pcs_top: DEPTH must be a power of two of at least 2");
      end
      if (VEC_ADDR >= (1 << PC_W)) begin : g_bad_vec
         $error("pcs_top: VEC_ADDR outside the program space");
      end
   endgenerate

   pcs_ev_e         ev;
   logic [PC_W-1:0] pc_q, pc_nx, pc_inc, push_val, stk_top;
   logic [HI_W-1:0] hi;
   logic            push, pop, gie_q, gie_nx;

   pcs_arb u_arb (
      .irq_i    (irq_i),
      .gie_i    (gie_q),
      .ret_i    (ret_i),
      .reti_i   (reti_i),
      .call_i   (call_i),
      .pcl_we_i (pcl_we_i),
      .adv_i    (adv_i),
      .ev_o     (ev)
   );

   pcs_hold #(.REG_W(REG_W), .HI_W(HI_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (lat_we_i),
      .wd_i  (lat_wd_i),
      .hi_o  (hi),
      .rd_o  (lat_o)
   );

   pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .pop_i  (pop),
      .din_i  (push_val),
      .top_o  (stk_top)
   );

   assign pc_inc = pc_q + ONE;

   always_comb begin
      pc_nx    = pc_q;
      push     = 1'b0;
      pop      = 1'b0;
      push_val = pc_inc;
      gie_nx   = gie_q;
      unique case (ev)
         EV_IRQ: begin
            pc_nx    = VEC;
            push     = 1'b1;
            push_val = pc_q;
            gie_nx   = 1'b0;
         end
         EV_POP: begin
            pc_nx = stk_top;
            pop   = 1'b1;
            if (reti_i) gie_nx = 1'b1;
         end
         EV_CALL: begin
            pc_nx = tgt_i;
            push  = 1'b1;
         end
         EV_PCL:  pc_nx = {hi, pcl_wd_i};
         EV_ADV:  pc_nx = pc_inc;
         default: pc_nx = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         gie_q <= 1'b1;
      end else begin
         pc_q  <= pc_nx;
         gie_q <= gie_nx;
      end
   end

   assign fetch_o = pc_q;
   assign pcl_o   = pc_q[REG_W-1:0];
   assign gie_o   = gie_q;

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
   parameter int unsigned PC_W     = 13,
   parameter int unsigned REG_W    = 8,
   parameter int unsigned VEC_ADDR = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv_i,
   input logic             call_i,
   input logic             ret_i,
   input logic             irq_i,
   input logic             reti_i,
   input logic [PC_W-1:0]  tgt_i,
   input logic             pcl_we_i,
   input logic [REG_W-1:0] pcl_wd_i,
   input logic             lat_we_i,
   input logic [REG_W-1:0] lat_wd_i,
   input logic [PC_W-1:0]  fetch_o,
   input logic [REG_W-1:0] pcl_o,
   input logic [REG_W-1:0] lat_o,
   input logic             gie_o
);

   localparam int unsigned HI_W = PC_W - REG_W;

   logic taken_irq, any_pop, quiet;
   assign taken_irq = irq_i && gie_o;
   assign any_pop   = ret_i || reti_i;
   assign quiet     = !taken_irq && !any_pop && !call_i && !pcl_we_i;

   // R2: a lone advance adds one
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && adv_i) |=> fetch_o == $past(fetch_o) + {{(PC_W-1){1'b0}}, 1'b1});

   // R2: no strobe, no motion
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !adv_i) |=> $stable(fetch_o));

   // R3: a call wins over lower events and lands on the target
   a_r3_call_target: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken_irq && !any_pop && call_i) |=> fetch_o == $past(tgt_i));

   // R5: a taken interrupt lands on the vector and clears the flag
   a_r5_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
      taken_irq |=> (fetch_o == PC_W'(VEC_ADDR)) && !gie_o);

   // R6: return-from-interrupt re-enables
   a_r6_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken_irq && reti_i) |=> gie_o);

   // R7: latch readback upper bits are zero
   a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lat_o[REG_W-1:HI_W] == '0);

   // R7: a latch write alone leaves the fetch address stable
   a_r7_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !adv_i && lat_we_i) |=> $stable(fetch_o));

   // R8: a low-byte write forms {old latch, byte}
   a_r8_pcl_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken_irq && !any_pop && !call_i && pcl_we_i)
      |=> fetch_o == {$past(lat_o[HI_W-1:0]), $past(pcl_wd_i)});

   // R8: low-byte readback mirrors the address
   a_r8_pcl_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      pcl_o == fetch_o[REG_W-1:0]);

endmodule

bind pcs_top pcs_chk #(
   .PC_W(PC_W), .REG_W(REG_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .call_i(call_i), .ret_i(ret_i),
   .irq_i(irq_i), .reti_i(reti_i), .tgt_i(tgt_i), .pcl_we_i(pcl_we_i),
   .pcl_wd_i(pcl_wd_i), .lat_we_i(lat_we_i), .lat_wd_i(lat_wd_i),
   .fetch_o(fetch_o), .pcl_o(pcl_o), .lat_o(lat_o), .gie_o(gie_o)
);

// File: tb/sim_pcs_top.sv
module sim_pcs_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 0, call_i = 0, ret_i = 0, irq_i = 0, reti_i = 0;
   logic [12:0] tgt_i = '0;
   logic        pcl_we_i = 0, lat_we_i = 0;
   logic [7:0]  pcl_wd_i = '0, lat_wd_i = '0;
   logic [12:0] fetch_o;
   logic [7:0]  pcl_o, lat_o;
   logic        gie_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   pcs_top u0 (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .call_i(call_i), .ret_i(ret_i),
      .irq_i(irq_i), .reti_i(reti_i), .tgt_i(tgt_i), .pcl_we_i(pcl_we_i),
      .pcl_wd_i(pcl_wd_i), .lat_we_i(lat_we_i), .lat_wd_i(lat_wd_i),
      .fetch_o(fetch_o), .pcl_o(pcl_o), .lat_o(lat_o), .gie_o(gie_o)
   );

   typedef struct {
      logic [12:0] pc;
      logic [7:0]  lat;
      logic        gie;
      string       tag;
   } exp_t;

   exp_t q[$];

   // Reference model state
   logic [12:0] mpc;
   logic [7:0]  mlat;
   logic        mgie;
   logic [12:0] mstk [8];
   int          msp;

   task automatic model_reset();
      mpc = '0; mlat = '0; mgie = 1'b1; msp = 0;
      for (int i = 0; i < 8; i++) mstk[i] = '0;
   endtask

   task automatic check(input string tag, input logic [12:0] pc,
                        input logic [7:0] lat, input logic gie);
      total++;
      if (fetch_o !== pc || pcl_o !== pc[7:0] || lat_o !== lat || gie_o !== gie) begin
         bad++;
         $display("FAIL %s: fetch=%h pcl=%h lat=%h gie=%b expected fetch=%h pcl=%h lat=%h gie=%b",
                  tag, fetch_o, pcl_o, lat_o, gie_o, pc, pc[7:0], lat, gie);
      end
   endtask

   // Driver: applies one cycle of strobes and queues the expected outcome
   task automatic step(input string tag, input bit a = 0, input bit c = 0,
                       input bit r = 0, input bit ri = 0, input bit iq = 0,
                       input logic [12:0] t = '0, input bit pw = 0,
                       input logic [7:0] pd = '0, input bit lw = 0,
                       input logic [7:0] ld = '0);
      exp_t e;
      @(negedge clk);
      adv_i = a; call_i = c; ret_i = r; reti_i = ri; irq_i = iq; tgt_i = t;
      pcl_we_i = pw; pcl_wd_i = pd; lat_we_i = lw; lat_wd_i = ld;
      if (iq && mgie) begin
         mstk[msp] = mpc; msp = (msp + 1) % 8; mpc = 13'h0004; mgie = 1'b0;
      end else if (r || ri) begin
         msp = (msp + 7) % 8; mpc = mstk[msp];
         if (ri) mgie = 1'b1;
      end else if (c) begin
         mstk[msp] = mpc + 13'd1; msp = (msp + 1) % 8; mpc = t;
      end else if (pw) begin
         mpc = {mlat[4:0], pd};
      end else if (a) begin
         mpc = mpc + 13'd1;
      end
      if (lw) mlat = {3'b000, ld[4:0]};
      e.pc = mpc; e.lat = mlat; e.gie = mgie; e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: compares each queued item after the clock edge it belongs to
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, e.pc, e.lat, e.gie);
      end
   end

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset state", 13'h0000, 8'h00, 1'b1);

      step(.tag("R1 return on empty stack after reset"), .r(1));
      step(.tag("R2 advance"), .a(1));
      step(.tag("R2 advance"), .a(1));
      step(.tag("R2 advance"), .a(1));
      step(.tag("R2 idle hold"));

      step(.tag("R3 call"), .c(1), .t(13'h0123));
      step(.tag("R2 advance in callee"), .a(1));
      step(.tag("R3 nested call"), .c(1), .t(13'h0456));
      step(.tag("R4 return inner"), .r(1));
      step(.tag("R4 return outer"), .r(1));

      step(.tag("R7 latch write masks upper bits"), .lw(1), .ld(8'hFF));
      step(.tag("R8 low-byte write uses old latch"), .pw(1), .pd(8'h34), .lw(1), .ld(8'h02));
      step(.tag("R8 low-byte write with new latch"), .pw(1), .pd(8'h9A));
      step(.tag("R7 latch write"), .lw(1), .ld(8'hDF));
      step(.tag("R8 jump to top of space"), .pw(1), .pd(8'hFF));
      step(.tag("R2 wrap to zero"), .a(1));

      step(.tag("R5 interrupt taken"), .iq(1));
      step(.tag("R5 interrupt ignored while disabled"), .iq(1), .a(1));
      step(.tag("R6 return from interrupt"), .ri(1));

      step(.tag("R10 interrupt beats all"), .iq(1), .r(1), .c(1), .t(13'h0777),
           .pw(1), .pd(8'h11), .a(1));
      step(.tag("R10 return beats call"), .r(1), .c(1), .t(13'h0888), .pw(1), .a(1));
      step(.tag("R10 call beats low-byte write"), .c(1), .t(13'h0999), .pw(1),
           .pd(8'h22), .a(1));
      step(.tag("R10 low-byte write beats advance"), .pw(1), .pd(8'h44), .a(1));
      step(.tag("R6 return from interrupt restores flag"), .ri(1));

      for (int i = 0; i < 9; i++)
         step(.tag("R9 push past depth"), .c(1), .t(13'(16 * (i + 1))));
      for (int i = 0; i < 10; i++)
         step(.tag("R9 pop through wrapped slots"), .r(1));

      step(.tag("R2 final idle"));
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule